// File: doc/BRIEF.md
# Crystal-Timed Watchdog with Reset Sequencing

This block is a fixed-timeout watchdog. A counter runs on a 32768 Hz enable derived from the real-time-clock crystal, and firmware must restart it with a register write strobe at least once every 1.5 seconds. If no restart comes in time, the block overflows. It then raises a chip reset request that has the same effect as the external reset pin. It holds that request for a fixed release window of about 125 ms, and then gives a one-cycle start strobe so the processor can begin fetching from address zero.

A sticky overflow flag lets boot code tell a watchdog restart apart from a power-up. Boot code clears the flag with a write. The external reset pin also clears it, and so does the sleep power mode. The flag keeps its value in the display-only (LCD) mode.

An optional warning interrupt rises a short lead time before the overflow, so firmware can log its state. Only two hardware inputs can switch the watchdog off: a board strap and the debug-enable line. No firmware-writable input can stop the count.

Top module: `crystal_wdt`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `chip_rst_req`, `cpu_start`, `ovf_flag` and `warn_irq` are all 0, and the timeout count is zero.
- R2: The count advances only on cycles where `rtc_tick` is 1. After TIMEOUT_TICKS consecutive ticks with no restart, an overflow occurs. The default of 49152 ticks is 1.5 s at 32768 Hz.
- R3: A `refresh_wr` pulse of 1 restarts the count from zero. A refresh that arrives on the same cycle as the terminal tick wins, and no overflow occurs.
- R4: While `wake` is 0, the count is held at zero and no overflow can occur.
- R5: From the cycle after the overflow tick, `chip_rst_req` is 1 for exactly HOLD_TICKS ticks (default 4100, about 125 ms). During that window, refresh, wake, disable and reset-pin inputs do not shorten it.
- R6: `cpu_start` is a single-cycle pulse on the cycle where `chip_rst_req` falls. The count then restarts from zero.
- R7: An overflow sets `ovf_flag` on the next cycle, and the flag stays set until it is cleared. If a clear source is active in the overflow cycle, the set still wins.
- R8: `ovf_flag` is cleared by `flag_clr_wr`, by `rst_pin`, or by `pwr_mode` = 2'b10 (sleep). The value `pwr_mode` = 2'b01 (LCD) and the value 2'b00 (run) leave it unchanged. A high `rst_pin` also restarts the count.
- R9: `warn_irq` is 1 exactly when `warn_ie` is 1, `chip_rst_req` is 0, and the count is at least TIMEOUT_TICKS − WARN_LEAD_TICKS. With the defaults that threshold is 49119, about 1 ms before overflow.
- R10: While `dbg_en` or `strap_off` is 1, the count is held at zero and no overflow can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| rtc_tick | input | 1 | One-cycle enable at the 32768 Hz crystal rate |
| rst_pin | input | 1 | External reset pin level, active high |
| wake | input | 1 | Internal wake level; 0 holds the count at zero |
| dbg_en | input | 1 | Debug-enable; 1 disables the watchdog |
| strap_off | input | 1 | Board strap; 1 disables the watchdog |
| refresh_wr | input | 1 | Firmware write of one to the refresh bit |
| flag_clr_wr | input | 1 | Firmware write that clears the overflow flag |
| warn_ie | input | 1 | Warning interrupt enable |
| pwr_mode | input | 2 | 00 run, 01 LCD, 10 sleep |
| chip_rst_req | output | 1 | Chip reset request during the hold window |
| cpu_start | output | 1 | One-cycle start-at-zero strobe |
| ovf_flag | output | 1 | Sticky overflow status |
| warn_irq | output | 1 | Early-warning interrupt |

## Verification
Two coincidences matter here. The first is a refresh strobe on the same cycle as the terminal tick. The second is a flag-clear write on the same cycle as the overflow. The bench steers a cycle-level model until the count is exactly one tick short of the limit, and then drives the refresh, or the clear, together with that tick. It expects no reset in the first case, and a set flag plus an active reset in the second. Random runs mix rare refreshes, wake drops, disables and mode changes, so both coincidences also occur unplanned, and every output is compared against the model on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_LCD   = 2'b01,
      PM_SLEEP = 2'b10
   } pwr_mode_e;

   typedef enum logic {
      PH_COUNT = 1'b0,
      PH_HOLD  = 1'b1
   } wdt_phase_e;

endpackage

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
   parameter int TIMEOUT   = 49152,
   parameter int WARN_LEAD = 33
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic active,
   input  logic warn_ie,
   output logic ovf,
   output logic warn_irq
);

   localparam int CNT_W = $clog2(TIMEOUT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == LAST);
   assign ovf    = active & ~restart & tick & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!active || restart || ovf) cnt <= '0;
      else if (tick)                      cnt <= cnt + 1'b1;
   end

   generate
      if (WARN_LEAD == 0) begin : g_no_warn
         assign warn_irq = 1'b0;
      end else begin : g_warn
         localparam logic [CNT_W-1:0] WARN_AT = CNT_W'(TIMEOUT - WARN_LEAD);
         assign warn_irq = warn_ie & active & (cnt >= WARN_AT);
      end
   endgenerate

   p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   p_tick_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart && tick && !at_end) |=> (cnt == $past(cnt) + 1'b1));
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart && !tick) |=> $stable(cnt));

endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
   import wdt_pkg::*;
#(
   parameter int HOLD = 4100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ovf,
   output logic hold_req,
   output logic start_pulse
);

   localparam int HOLD_W = $clog2(HOLD);
   localparam logic [HOLD_W-1:0] HLAST = HOLD_W'(HOLD - 1);

   wdt_phase_e       phase;
   logic [HOLD_W-1:0] hcnt;
   logic             start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_COUNT;
         hcnt    <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (phase)
            PH_COUNT: begin
               if (ovf) begin
                  phase <= PH_HOLD;
                  hcnt  <= '0;
               end
            end
            PH_HOLD: begin
               if (tick) begin
                  if (hcnt == HLAST) begin
                     phase   <= PH_COUNT;
                     start_q <= 1'b1;
                  end else begin
                     hcnt <= hcnt + 1'b1;
                  end
               end
            end
            default: phase <= PH_COUNT;
         endcase
      end
   end

   assign hold_req    = (phase == PH_HOLD);
   assign start_pulse = start_q;

   p_hold_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> hold_req);
   p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req && !tick) |=> hold_req);
   p_start_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (!hold_req && $past(hold_req)));
   p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(flag));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

endmodule

// File: rtl/crystal_wdt.sv
module crystal_wdt
   import wdt_pkg::*;
#(
   parameter int TIMEOUT_TICKS   = 49152,
   parameter int WARN_LEAD_TICKS = 33,
   parameter int HOLD_TICKS      = 4100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rtc_tick,
   input  logic       rst_pin,
   input  logic       wake,
   input  logic       dbg_en,
   input  logic       strap_off,
   input  logic       refresh_wr,
   input  logic       flag_clr_wr,
   input  logic       warn_ie,
   input  logic [1:0] pwr_mode,
   output logic       chip_rst_req,
   output logic       cpu_start,
   output logic       ovf_flag,
   output logic       warn_irq
);

   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("TIMEOUT_TICKS must be at least 2");
      end
      if (WARN_LEAD_TICKS < 0 || WARN_LEAD_TICKS >= TIMEOUT_TICKS) begin : g_bad_lead
         $error("WARN_LEAD_TICKS must lie in [0, TIMEOUT_TICKS)");
      end
      if (HOLD_TICKS < 2) begin : g_bad_hold
         $error("HOLD_TICKS must be at least 2");
      end
   endgenerate

   logic wdt_off;
   logic restart;
   logic active;
   logic ovf;
   logic hold;
   logic flag_clr;

   assign wdt_off  = dbg_en | strap_off;
   assign restart  = refresh_wr | ~wake | wdt_off | rst_pin;
   assign active   = ~hold;
   assign flag_clr = flag_clr_wr | rst_pin | (pwr_mode == PM_SLEEP);

   wdt_timeout_ctr #(
      .TIMEOUT   (TIMEOUT_TICKS),
      .WARN_LEAD (WARN_LEAD_TICKS)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (rtc_tick),
      .restart  (restart),
      .active   (active),
      .warn_ie  (warn_ie),
      .ovf      (ovf),
      .warn_irq (warn_irq)
   );

   wdt_reset_seq #(
      .HOLD (HOLD_TICKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (rtc_tick),
      .ovf         (ovf),
      .hold_req    (hold),
      .start_pulse (cpu_start)
   );

   wdt_status u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (ovf),
      .clr  (flag_clr),
      .flag (ovf_flag)
   );

   assign chip_rst_req = hold;

   p_off_no_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_off && !chip_rst_req) |=> !chip_rst_req);
   p_sleepwake_no_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake && !chip_rst_req) |=> !chip_rst_req);
   p_warn_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      warn_irq |-> (warn_ie && !chip_rst_req));

endmodule

// File: tb/crystal_wdt_bench.sv
`timescale 1ns/1ps
module crystal_wdt_bench;

   localparam int T = 200;
   localparam int L = 10;
   localparam int H = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic b_tick = 1'b0, b_pin = 1'b0, b_wake = 1'b1, b_dbg = 1'b0, b_strap = 1'b0;
   logic b_ref = 1'b0, b_clr = 1'b0, b_wie = 1'b0;
   logic [1:0] b_mode = 2'b00;
   logic chip_rst_req, cpu_start, ovf_flag, warn_irq;

   int  m_cnt = 0, m_hcnt = 0;
   bit  m_hold = 0, m_start = 0, m_flag = 0;
   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   always #2.5 clk = ~clk;

   crystal_wdt #(
      .TIMEOUT_TICKS   (T),
      .WARN_LEAD_TICKS (L),
      .HOLD_TICKS      (H)
   ) u_crystal_wdt (
      .clk          (clk),
      .rst_n        (rst_n),
      .rtc_tick     (b_tick),
      .rst_pin      (b_pin),
      .wake         (b_wake),
      .dbg_en       (b_dbg),
      .strap_off    (b_strap),
      .refresh_wr   (b_ref),
      .flag_clr_wr  (b_clr),
      .warn_ie      (b_wie),
      .pwr_mode     (b_mode),
      .chip_rst_req (chip_rst_req),
      .cpu_start    (cpu_start),
      .ovf_flag     (ovf_flag),
      .warn_irq     (warn_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_warn();
      return b_wie && !m_hold && (m_cnt >= T - L);
   endfunction

   task automatic compare_all();
      check("R5 chip_rst_req", chip_rst_req, m_hold);
      check("R6 cpu_start", cpu_start, m_start);
      check("R7 ovf_flag", ovf_flag, m_flag);
      check("R9 warn_irq", warn_irq, exp_warn());
   endtask

   // One clock: model next state from current inputs, advance, compare at negedge
   task automatic step();
      int n_cnt = m_cnt;
      int n_hcnt = m_hcnt;
      bit n_hold = m_hold;
      bit n_start = 0;
      bit n_flag = m_flag;
      bit ovf = 0;
      bit rs;
      rs = b_ref | ~b_wake | b_dbg | b_strap | b_pin;
      if (!m_hold) begin
         if (rs) n_cnt = 0;
         else if (b_tick) begin
            if (m_cnt == T - 1) begin
               ovf = 1; n_cnt = 0; n_hold = 1; n_hcnt = 0;
            end else n_cnt = m_cnt + 1;
         end
      end else begin
         n_cnt = 0;
         if (b_tick) begin
            if (m_hcnt == H - 1) begin
               n_hold = 0; n_start = 1;
            end else n_hcnt = m_hcnt + 1;
         end
      end
      if (ovf) n_flag = 1;
      else if (b_clr || b_pin || b_mode == 2'b10) n_flag = 0;
      @(posedge clk);
      @(negedge clk);
      m_cnt = n_cnt; m_hcnt = n_hcnt; m_hold = n_hold;
      m_start = n_start; m_flag = n_flag;
      compare_all();
   endtask

   task automatic idle_inputs();
      b_tick = 0; b_pin = 0; b_wake = 1; b_dbg = 0; b_strap = 0;
      b_ref = 0; b_clr = 0; b_mode = 2'b00;
   endtask

   task automatic run_to_terminal();
      idle_inputs();
      b_tick = 1;
      for (int i = 0; i < 4 * (T + H); i++) begin
         if (!m_hold && m_cnt == T - 1) break;
         step();
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      idle_inputs();
      repeat (4) @(negedge clk);
      // R1: held in reset
      check("R1 rst chip_rst_req", chip_rst_req, 0);
      check("R1 rst cpu_start", cpu_start, 0);
      check("R1 rst ovf_flag", ovf_flag, 0);
      check("R1 rst warn_irq", warn_irq, 0);
      rst_n = 1;
      step();
      check("R1 post-reset ovf_flag", ovf_flag, 0);

      // R2/R9: plain timeout with warning enabled
      b_wie = 1;
      run_to_terminal();
      check("R9 warn before overflow", warn_irq, 1);
      step();
      check("R2 overflow reached", chip_rst_req, 1);
      for (int i = 0; i < 2 * H + 4 && m_hold; i++) begin
         b_ref = ($urandom % 3 == 0);
         b_wake = ($urandom % 4 != 0);
         b_dbg = ($urandom % 5 == 0);
         step();
      end
      check("R5 hold ended after window", chip_rst_req, 0);
      check("R6 start pulse", cpu_start, 1);
      idle_inputs();

      // R3: refresh on the terminal tick wins
      run_to_terminal();
      b_ref = 1;
      step();
      check("R3 refresh at terminal tick", chip_rst_req, 0);
      b_ref = 0;

      // R7: clear write on the overflow cycle loses
      b_clr = 1;
      step();
      b_clr = 0;
      run_to_terminal();
      b_clr = 1;
      step();
      check("R7 set beats clear", ovf_flag, 1);
      b_clr = 0;
      b_mode = 2'b01;
      step();
      check("R8 LCD keeps flag", ovf_flag, 1);
      b_mode = 2'b10;
      step();
      check("R8 sleep clears flag", ovf_flag, 0);
      b_mode = 2'b00;
      for (int i = 0; i < 2 * H + 4 && m_hold; i++) step();

      // R10 / R4: disables and wake low over longer than a timeout
      idle_inputs(); b_tick = 1; b_strap = 1;
      for (int i = 0; i < 2 * T; i++) step();
      check("R10 strap blocks overflow", chip_rst_req, 0);
      b_strap = 0; b_dbg = 1;
      for (int i = 0; i < 2 * T; i++) step();
      check("R10 debug blocks overflow", chip_rst_req, 0);
      b_dbg = 0; b_wake = 0;
      for (int i = 0; i < 2 * T; i++) step();
      check("R4 wake low blocks overflow", chip_rst_req, 0);
      b_wake = 1;

      // Constrained random segments, quiet and busy refresh rates alternating
      for (int seg = 0; seg < 16; seg++) begin
         for (int k = 0; k < 1000; k++) begin
            int r;
            b_tick  = ($urandom % 2 == 0);
            b_ref   = (seg % 2 == 1) ? ($urandom % 40 == 0) : ($urandom % 3000 == 0);
            b_wake  = ($urandom % 400 != 0);
            b_dbg   = ($urandom % 900 == 0);
            b_strap = ($urandom % 900 == 0);
            b_pin   = ($urandom % 1500 == 0);
            b_clr   = ($urandom % 150 == 0);
            r = $urandom % 300;
            b_mode  = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : 2'b00;
            if ($urandom % 100 == 0) b_wie = ~b_wie;
            step();
         end
      end

      if (!done) begin
         done = 1;
         summary();
         $finish;
      end
   end

endmodule